// File: doc/BRIEF.md
# Interrupt-Enable In-Flight Gate

This block sits in a processor core between the interrupt controller and the decode stage. Every cycle it decides whether a pending interrupt request may be taken. A speculative instruction that changes the master interrupt-enable flag could later turn out to disable interrupts. To avoid that hazard, the gate counts the flag-changing operations that have passed decode but have not yet retired. The interrupt is taken only when that count is zero and the committed enable flag is set. There is no pipeline drain.

Three kinds of operation can change the flag: an enable instruction, a disable instruction, and the delivery of an interrupt. An exception leaves the flag alone. Decode supplies the classification of each instruction. When the gate takes an interrupt, it injects the interrupt at decode and requests a light purge of the fetch buffer in the same cycle. The injected delivery then counts as a flag-changing operation in flight.

A strict mode can be selected per cycle. In strict mode, any control-register instruction in flight also holds interrupts off until it retires or is squashed. On a pipeline flush, decode reports how many flag-changing and control-register operations were squashed, and the gate subtracts those numbers at once.

Top module: `irq_gate`

## Requirements
- R1: After reset the pending count is 0, the control-register count is 0, the committed enable flag is 0, `countError` is 0, and no interrupt is accepted.
- R2: The pending count goes up by one at the clock edge for each flag-changing operation passing decode. These are `decFlagOp` and the gate's own accepted interrupt, which counts as a delivery entering decode. The count goes down by one for a retiring enable, disable or delivery.
- R3: While the pending count is non-zero, `intAccept` stays 0 whatever `intReq` is.
- R4: `intAccept` is 1 in the same cycle as `intReq` when the pending count is 0 and the committed enable flag is 1, subject to R6. `canAccept` shows the same condition without the request.
- R5: `injectDecode` and `purgeFetch` are 1 in exactly the cycles where `intAccept` is 1.
- R6: With `strictMode` at 1, a non-zero control-register count blocks acceptance. That count goes up with `decCsrOp`, goes down with `retCsrOp`, and drops by `flushCsrCnt` on a flush. With `strictMode` at 0, the control-register count has no effect on acceptance.
- R7: `flushFlagCnt` is subtracted from the pending count at the same clock edge as any increment or decrement in that cycle.
- R8: When one flag-changing operation enters decode and one retires in the same cycle, with no flush, the pending count is unchanged.
- R9: The committed enable flag changes only when a flag-changing operation retires. A retiring enable sets it to 1. A retiring disable or delivery clears it to 0, and the clear wins if a set arrives in the same cycle.
- R10: If an update would take either count below 0 or above its maximum (15 with defaults), the count clamps at the bound and `countError` is 1 for the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strictMode | input | 1 | 1: in-flight control-register instructions also block acceptance |
| intReq | input | 1 | Interrupt controller asks the core to take an interrupt |
| decFlagOp | input | 1 | An enable or disable instruction passes decode this cycle |
| decCsrOp | input | 1 | A control-register instruction passes decode this cycle |
| retEnable | input | 1 | An enable instruction retires this cycle |
| retDisable | input | 1 | A disable instruction retires this cycle |
| retDeliver | input | 1 | An interrupt delivery retires this cycle |
| retCsrOp | input | 1 | A control-register instruction retires this cycle |
| flushFlagCnt | input | CNT_W | Number of flag-changing operations squashed this cycle |
| flushCsrCnt | input | CNT_W | Number of control-register operations squashed this cycle |
| intAccept | output | 1 | Interrupt taken this cycle |
| injectDecode | output | 1 | Insert the interrupt delivery at decode |
| purgeFetch | output | 1 | Discard the fetch buffer contents |
| canAccept | output | 1 | Gate is open, request or not |
| pendCount | output | CNT_W | Flag-changing operations in flight |
| pendCsr | output | CNT_W | Control-register operations in flight |
| enableFlag | output | 1 | Committed master interrupt-enable flag |
| countError | output | 1 | A count clamped on the previous edge |

## Verification
`intAccept`, `injectDecode`, `purgeFetch` and `canAccept` are combinational from the registered counts and flag. They are due in the same cycle as the stimulus, so the bench checks them shortly after driving inputs on the falling edge. The pending count, the control-register count and the enable flag take the stimulus at the next rising edge. `countError` is registered once more at that same edge. All of these are read just after that rising edge, and never before it. The walk of vectors runs accept, block, flush, concurrent enter/retire and strict-mode sequences. Each vector holds the state its predecessors leave behind. Directed tests then drive both counter bounds.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef struct packed {
    logic       accept;
    logic [1:0] flagInc;
    logic       flagDec;
    logic       setFlag;
    logic       clrFlag;
    logic       csrInc;
    logic       csrDec;
  } gateStrobes_t;

endpackage

// File: rtl/irq_gate_counter.sv
module irq_gate_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       inc,
  input  logic             dec,
  input  logic [CNT_W-1:0] sub,
  output logic [CNT_W-1:0] count,
  output logic             bad
);
  localparam int WIDE_W = CNT_W + 2;
  localparam logic [WIDE_W-1:0] MAX_WIDE = {2'b00, {CNT_W{1'b1}}};

  logic [WIDE_W-1:0] upSum;
  logic [WIDE_W-1:0] downSum;
  logic [WIDE_W-1:0] diff;
  logic [CNT_W-1:0]  countNext;

  always_comb begin
    upSum   = {2'b00, count} + {{CNT_W{1'b0}}, inc};
    downSum = {2'b00, sub} + {{(CNT_W+1){1'b0}}, dec};
    diff    = upSum - downSum;
    bad     = 1'b0;
    if (downSum > upSum) begin
      countNext = '0;
      bad       = 1'b1;
    end else if (diff > MAX_WIDE) begin
      countNext = {CNT_W{1'b1}};
      bad       = 1'b1;
    end else begin
      countNext = diff[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= countNext;
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
(
  input  logic         intReq,
  input  logic         strictMode,
  input  logic         decFlagOp,
  input  logic         decCsrOp,
  input  logic         retEnable,
  input  logic         retDisable,
  input  logic         retDeliver,
  input  logic         retCsrOp,
  input  logic         countZero,
  input  logic         csrZero,
  input  logic         enableFlag,
  output logic         canAccept,
  output gateStrobes_t strobes
);
  always_comb begin
    canAccept       = countZero && enableFlag && (!strictMode || csrZero);
    strobes.accept  = intReq && canAccept;
    // the injected delivery enters decode alongside any decoded flag op
    strobes.flagInc = {1'b0, decFlagOp} + {1'b0, strobes.accept};
    strobes.flagDec = retEnable || retDisable || retDeliver;
    strobes.clrFlag = retDisable || retDeliver;
    strobes.setFlag = retEnable && !strobes.clrFlag;
    strobes.csrInc  = decCsrOp;
    strobes.csrDec  = retCsrOp;
  end
endmodule

// File: rtl/irq_gate_dp.sv
module irq_gate_dp
  import irq_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gateStrobes_t     strobes,
  input  logic [CNT_W-1:0] flushFlagCnt,
  input  logic [CNT_W-1:0] flushCsrCnt,
  output logic [CNT_W-1:0] pendCount,
  output logic [CNT_W-1:0] pendCsr,
  output logic             enableFlag,
  output logic             countZero,
  output logic             csrZero,
  output logic             countError
);
  logic flagBad;
  logic csrBad;

  irq_gate_counter #(.CNT_W(CNT_W)) u_flagCnt (
    .clk(clk), .rst_n(rst_n),
    .inc(strobes.flagInc), .dec(strobes.flagDec), .sub(flushFlagCnt),
    .count(pendCount), .bad(flagBad)
  );

  irq_gate_counter #(.CNT_W(CNT_W)) u_csrCnt (
    .clk(clk), .rst_n(rst_n),
    .inc({1'b0, strobes.csrInc}), .dec(strobes.csrDec), .sub(flushCsrCnt),
    .count(pendCsr), .bad(csrBad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableFlag <= 1'b0;
      countError <= 1'b0;
    end else begin
      if (strobes.clrFlag)      enableFlag <= 1'b0;
      else if (strobes.setFlag) enableFlag <= 1'b1;
      countError <= flagBad || csrBad;
    end
  end

  assign countZero = (pendCount == '0);
  assign csrZero   = (pendCsr == '0);
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strictMode,
  input  logic             intReq,
  input  logic             decFlagOp,
  input  logic             decCsrOp,
  input  logic             retEnable,
  input  logic             retDisable,
  input  logic             retDeliver,
  input  logic             retCsrOp,
  input  logic [CNT_W-1:0] flushFlagCnt,
  input  logic [CNT_W-1:0] flushCsrCnt,
  output logic             intAccept,
  output logic             injectDecode,
  output logic             purgeFetch,
  output logic             canAccept,
  output logic [CNT_W-1:0] pendCount,
  output logic [CNT_W-1:0] pendCsr,
  output logic             enableFlag,
  output logic             countError
);
  gateStrobes_t strobes;
  logic countZero;
  logic csrZero;

  irq_gate_ctrl u_ctrl (
    .intReq(intReq), .strictMode(strictMode),
    .decFlagOp(decFlagOp), .decCsrOp(decCsrOp),
    .retEnable(retEnable), .retDisable(retDisable),
    .retDeliver(retDeliver), .retCsrOp(retCsrOp),
    .countZero(countZero), .csrZero(csrZero), .enableFlag(enableFlag),
    .canAccept(canAccept), .strobes(strobes)
  );

  irq_gate_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .flushFlagCnt(flushFlagCnt), .flushCsrCnt(flushCsrCnt),
    .pendCount(pendCount), .pendCsr(pendCsr), .enableFlag(enableFlag),
    .countZero(countZero), .csrZero(csrZero), .countError(countError)
  );

  assign intAccept    = strobes.accept;
  assign injectDecode = strobes.accept;
  assign purgeFetch   = strobes.accept;
endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strictMode,
  input logic             intReq,
  input logic             decFlagOp,
  input logic             retEnable,
  input logic             retDisable,
  input logic             retDeliver,
  input logic [CNT_W-1:0] flushFlagCnt,
  input logic             intAccept,
  input logic             injectDecode,
  input logic             purgeFetch,
  input logic [CNT_W-1:0] pendCount,
  input logic [CNT_W-1:0] pendCsr,
  input logic             enableFlag,
  input logic             countError
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic anyRet;
  assign anyRet = retEnable || retDisable || retDeliver;

  assert_block_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pendCount != '0) |-> !intAccept);

  assert_accept_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    intAccept |-> (intReq && pendCount == '0 && enableFlag));

  assert_side_effects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (intAccept == injectDecode) && (intAccept == purgeFetch));

  assert_strict_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strictMode && pendCsr != '0) |-> !intAccept);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (decFlagOp && !intAccept && !anyRet && flushFlagCnt == '0 && pendCount != MAXV)
    |=> pendCount == $past(pendCount) + ONE);

  assert_hold_on_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (decFlagOp && !intAccept && anyRet && flushFlagCnt == '0)
    |=> $stable(pendCount));

  assert_flag_at_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !anyRet |=> $stable(enableFlag));

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (anyRet && pendCount == '0 && !decFlagOp && !intAccept) |=> countError);
endmodule

bind irq_gate irq_gate_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_irq_gate.sv
module test_irq_gate;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic       req;
    logic       strict;
    logic       dF;
    logic       dC;
    logic       rE;
    logic       rD;
    logic       rV;
    logic       rC;
    logic [3:0] fF;
    logic [3:0] fC;
    logic       eAcc;
    logic [3:0] eCnt;
    logic       eEn;
    logic [3:0] eCsr;
  } vec_t;

  localparam int NV = 23;
  // req strict dF dC rE rD rV rC fF fC | acc cnt en csr
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd0}, // flag still 0
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b0,4'd0}, // enable enters
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b1,4'd0}, // enable retires
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b1,4'd1,1'b1,4'd0}, // accepted, delivery counted
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b1,4'd0}, // R3 blocked
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd0}, // delivery retires
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b0,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b1,4'd0}, // R8 pair
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd0}, // R3 with flag 1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b0,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd2,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2,4'd0, 1'b0,4'd0,1'b0,4'd0}, // R7 flush
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd1,1'b0,4'd0},
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd1,4'd0, 1'b0,4'd0,1'b1,4'd0}, // R7 with enter+retire
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b1,4'd1},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b1,4'd1}, // R6 strict block
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b1,4'd1,1'b1,4'd1}, // R6 lax mode
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd1},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,4'd2, 1'b0,4'd0,1'b0,4'd0}, // csr flush
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b1,4'd0}, // R8 from zero
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,4'd0, 1'b1,4'd1,1'b1,4'd0}, // strict, nothing in flight
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd0,4'd0, 1'b0,4'd0,1'b0,4'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strictMode = 1'b0, intReq = 1'b0, decFlagOp = 1'b0, decCsrOp = 1'b0;
  logic retEnable = 1'b0, retDisable = 1'b0, retDeliver = 1'b0, retCsrOp = 1'b0;
  logic [CNT_W-1:0] flushFlagCnt = '0, flushCsrCnt = '0;
  logic intAccept, injectDecode, purgeFetch, canAccept, enableFlag, countError;
  logic [CNT_W-1:0] pendCount, pendCsr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_gate #(.CNT_W(CNT_W)) i_irq_gate (
    .clk(clk), .rst_n(rst_n), .strictMode(strictMode), .intReq(intReq),
    .decFlagOp(decFlagOp), .decCsrOp(decCsrOp),
    .retEnable(retEnable), .retDisable(retDisable), .retDeliver(retDeliver),
    .retCsrOp(retCsrOp), .flushFlagCnt(flushFlagCnt), .flushCsrCnt(flushCsrCnt),
    .intAccept(intAccept), .injectDecode(injectDecode), .purgeFetch(purgeFetch),
    .canAccept(canAccept), .pendCount(pendCount), .pendCsr(pendCsr),
    .enableFlag(enableFlag), .countError(countError)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    intReq = v.req; strictMode = v.strict; decFlagOp = v.dF; decCsrOp = v.dC;
    retEnable = v.rE; retDisable = v.rD; retDeliver = v.rV; retCsrOp = v.rC;
    flushFlagCnt = v.fF; flushCsrCnt = v.fC;
  endtask

  function automatic vec_t idle();
    vec_t v = '0;
    return v;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 count", int'(pendCount), 0);
    check("R1 csr", int'(pendCsr), 0);
    check("R1 flag", int'(enableFlag), 0);
    check("R1 error", int'(countError), 0);
    intReq = 1'b1;
    #1 check("R1 accept", int'(intAccept), 0);
    intReq = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("R4 accept row %0d", i), int'(intAccept), int'(VEC[i].eAcc));
      check($sformatf("R5 inject/purge row %0d", i),
            int'({injectDecode, purgeFetch}), VEC[i].eAcc ? 3 : 0);
      @(posedge clk); #1;
      check($sformatf("R2 count row %0d", i), int'(pendCount), int'(VEC[i].eCnt));
      check($sformatf("R9 flag row %0d", i), int'(enableFlag), int'(VEC[i].eEn));
      check($sformatf("R6 csr count row %0d", i), int'(pendCsr), int'(VEC[i].eCsr));
    end

    // R10 underflow: disable retires with nothing counted
    @(negedge clk); v = idle(); v.rD = 1'b1; drive(v);
    @(posedge clk); #1;
    check("R10 underflow error", int'(countError), 1);
    check("R10 underflow clamp", int'(pendCount), 0);
    @(negedge clk); drive(idle());
    @(posedge clk); #1;
    check("R10 error one cycle", int'(countError), 0);

    // R10 overflow: sixteen enters into a four-bit count
    for (int k = 0; k < 15; k++) begin
      @(negedge clk); v = idle(); v.dF = 1'b1; drive(v);
    end
    @(posedge clk); #1;
    check("R10 count at max", int'(pendCount), 15);
    check("R10 no error at max", int'(countError), 0);
    @(negedge clk); v = idle(); v.dF = 1'b1; drive(v);
    @(posedge clk); #1;
    check("R10 overflow error", int'(countError), 1);
    check("R10 overflow clamp", int'(pendCount), 15);
    @(negedge clk); v = idle(); v.fF = 4'd15; v.rE = 1'b0; drive(v);
    @(posedge clk); #1;
    check("R7 full flush", int'(pendCount), 0);

    // R4 canAccept follows the gate without a request
    @(negedge clk); v = idle(); v.dF = 1'b1; v.rE = 1'b1; drive(v);
    @(posedge clk); #1;
    @(negedge clk); drive(idle()); #1;
    check("R4 canAccept open", int'(canAccept), 1);
    check("R4 no accept without request", int'(intAccept), 0);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule